// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Paired Result Registers

This block performs 32-bit integer multiplication and division, in signed and unsigned forms, for a processor core. A command carries a 6-bit function code and two operands, which are named after the source register fields they come from: `cmd_rs` and `cmd_rt`. A multiply or divide command starts an iterative operation. The operation takes one setup cycle and then one cycle per operand bit. The 64-bit outcome goes into two result registers, HI and LO, and both are written on the same clock edge.

Software reaches the two result registers through move commands. A move-to command loads one register from `cmd_rs`. A move-from command returns the value of one register on `rd_data`, in the same cycle as the command. While an operation is running, `busy` is high and `cmd_ready` is low. Any command that arrives in that time is held off until the operation ends, so a read never returns a partial result.

Top module: `muldiv_unit`

## Requirements
- R1: The unit decodes these function codes: 0x18 signed multiply, 0x19 unsigned multiply, 0x1a signed divide, 0x1b unsigned divide, 0x10 read HI, 0x11 write HI, 0x12 read LO, 0x13 write LO. The first operand is `cmd_rs` and the second is `cmd_rt`.
- R2: A multiply leaves the high 32 bits of the 64-bit product in HI and the low 32 bits in LO. Code 0x18 treats both operands as two's complement. Code 0x19 treats them as unsigned.
- R3: An unsigned divide leaves the quotient in LO and the remainder in HI.
- R4: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. Dividing -2^31 by -1 gives LO = 0x80000000 and HI = 0.
- R5: Dividing by zero, signed or unsigned, gives LO = 0xFFFFFFFF and HI = the dividend, unchanged. It takes the same number of cycles as any other divide.
- R6: `busy` goes high on the cycle after a multiply or divide is accepted. It stays high for exactly 33 cycles. HI and LO keep their old values while `busy` is high and are both updated when `busy` falls.
- R7: While `busy` is high, `cmd_ready` is low and no command takes effect. A read that is held off has `rd_valid` low, and once `busy` falls it returns the new result.
- R8: When the unit is idle, a write to HI or to LO changes only that register, to `cmd_rs`. The new value can be read on the very next cycle, and `busy` stays low.
- R9: When the unit is idle, a read of HI or LO drives `rd_valid` high and `rd_data` with the register value in the same cycle. A read changes neither register.
- R10: A function code outside the eight listed in R1 is accepted and has no effect. HI, LO and `busy` all stay unchanged.
- R11: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is being presented |
| cmd_func | input | 6 | Function code of the command |
| cmd_rs | input | 32 | First operand; also the value for a write to HI or LO |
| cmd_rt | input | 32 | Second operand |
| cmd_ready | output | 1 | The command is accepted on this clock edge |
| busy | output | 1 | A multiply or divide is in progress |
| rd_valid | output | 1 | `rd_data` holds the value of an accepted read |
| rd_data | output | 32 | Value of HI or LO for a read |

## Verification
Two situations are hardest to reach: a read, or a register write, that arrives while an operation is still running. The stimulus starts an operation, then presents a read of HI on the next cycle and holds it until it is accepted. It checks that the read waits the full 33 cycles and then returns the new result. In a second case, a write to HI is presented during an operation and then withdrawn before the operation ends; the check is that this write never takes effect. The arithmetic corners (the most negative number as an operand, division by zero, and signed divides of each sign pattern) are driven directly. Random operations of all four kinds are mixed in with them.

// File: rtl/muldiv_pkg.sv
// Shared encodings for the multiply/divide unit.
// Assumes a 6-bit function field, as used by the core's decoder.
package muldiv_pkg;
    localparam logic [5:0] FN_RD_HI   = 6'h10;
    localparam logic [5:0] FN_WR_HI   = 6'h11;
    localparam logic [5:0] FN_RD_LO   = 6'h12;
    localparam logic [5:0] FN_WR_LO   = 6'h13;
    localparam logic [5:0] FN_MUL_S   = 6'h18;
    localparam logic [5:0] FN_MUL_U   = 6'h19;
    localparam logic [5:0] FN_DIV_S   = 6'h1a;
    localparam logic [5:0] FN_DIV_U   = 6'h1b;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER
    } mdu_state_e;

    typedef struct packed {
        logic is_div;
        logic is_signed;
    } mdu_op_t;
endpackage

// File: rtl/mdu_prep.sv
// Operand conditioning: turns each raw operand into a sign flag and an
// unsigned magnitude. Assumes two's complement; the magnitude of the most
// negative value, 2^(W-1), still fits in W unsigned bits.
module mdu_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         is_signed,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_a,
    output logic         neg_b
);
    logic [W-1:0] raw [2];
    logic [W-1:0] mag [2];
    logic [1:0]   neg;

    assign raw[0] = opa;
    assign raw[1] = opb;

    // The same sign/magnitude conversion, once for each operand.
    for (genvar i = 0; i < 2; i++) begin : g_opnd
        always_comb begin
            neg[i] = is_signed & raw[i][W-1];
            mag[i] = neg[i] ? (~raw[i] + 1'b1) : raw[i];
        end
    end

    assign mag_a = mag[0];
    assign mag_b = mag[1];
    assign neg_a = neg[0];
    assign neg_b = neg[1];
endmodule

// File: rtl/mdu_mul_step.sv
// One radix-2 shift-add step of an unsigned multiply.
// The work word holds {partial product high half, remaining multiplier bits}.
// Bit 0 decides whether the multiplicand is added, then the word shifts right.
module mdu_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_in,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] work_out
);
    logic [W:0] sum;

    // Add the multiplicand when bit 0 is set, then shift right by one.
    always_comb begin
        sum      = {1'b0, work_in[2*W-1:W]} + (work_in[0] ? {1'b0, mcand} : '0);
        work_out = {sum, work_in[W-1:1]};
    end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division step on unsigned magnitudes.
// The work word holds {partial remainder, dividend bits still to enter / quotient}.
// A zero divisor always subtracts successfully, so the quotient fills with ones.
module mdu_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_in,
    input  logic [W-1:0]   dvsr,
    output logic [2*W-1:0] work_out
);
    logic [W:0] shifted;
    logic [W:0] diff;

    // Shift in the next dividend bit and try to subtract the divisor.
    always_comb begin
        shifted = {work_in[2*W-1:W], work_in[W-1]};
        diff    = shifted - {1'b0, dvsr};
        if (!diff[W]) begin
            work_out = {diff[W-1:0], work_in[W-2:0], 1'b1};
        end else begin
            work_out = {shifted[W-1:0], work_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdu_finish.sv
// Result formation: applies the signs to the unsigned result and handles the
// zero divisor. Assumes work holds the magnitude result after the last step:
// the full product for a multiply, {remainder, quotient} for a divide.
module mdu_finish #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work,
    input  logic           is_div,
    input  logic           neg_a,
    input  logic           neg_b,
    input  logic           div_zero,
    input  logic [W-1:0]   dividend,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;

    // Pick the signed multiply or divide result, with the zero-divisor case first.
    always_comb begin
        prod = (neg_a ^ neg_b) ? (~work + 1'b1) : work;
        quo  = (neg_a ^ neg_b) ? (~work[W-1:0] + 1'b1) : work[W-1:0];
        rem  = neg_a ? (~work[2*W-1:W] + 1'b1) : work[2*W-1:W];
        if (!is_div) begin
            res_hi = prod[2*W-1:W];
            res_lo = prod[W-1:0];
        end else if (div_zero) begin
            res_hi = dividend;
            res_lo = '1;
        end else begin
            res_hi = rem;
            res_lo = quo;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
// Multiply/divide unit with HI/LO result registers.
// Accepts one command per cycle while idle. A multiply or divide spends one
// setup cycle plus W step cycles, then writes HI and LO together. Reads and
// writes of HI/LO take effect at once while idle; every command is held off
// (cmd_ready low) while an operation is in progress.
module muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [5:0]   cmd_func,
    input  logic [W-1:0] cmd_rs,
    input  logic [W-1:0] cmd_rt,
    output logic         cmd_ready,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    import muldiv_pkg::*;

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    mdu_state_e     state_q;
    mdu_op_t        op_q;
    logic [W-1:0]   a_q, b_q, opnd_q;
    logic           neg_a_q, neg_b_q, div_zero_q;
    logic [2*W-1:0] work_q;
    logic [CNT_W-1:0] step_q;
    logic [W-1:0]   hi_q, lo_q;

    logic           accept, is_start, is_rd, is_wr_hi, is_wr_lo;
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_a, neg_b;
    logic [2*W-1:0] mul_next, div_next, step_next;
    logic [W-1:0]   fin_hi, fin_lo;

    // Command decode and handshake.
    always_comb begin
        is_start = (cmd_func == FN_MUL_S) || (cmd_func == FN_MUL_U) ||
                   (cmd_func == FN_DIV_S) || (cmd_func == FN_DIV_U);
        is_rd    = (cmd_func == FN_RD_HI) || (cmd_func == FN_RD_LO);
        is_wr_hi = (cmd_func == FN_WR_HI);
        is_wr_lo = (cmd_func == FN_WR_LO);
        busy     = (state_q != ST_IDLE);
        cmd_ready = !busy;
        accept   = cmd_valid && cmd_ready;
        rd_valid = accept && is_rd;
        rd_data  = (cmd_func == FN_RD_HI) ? hi_q : lo_q;
    end

    mdu_prep #(.W(W)) u_prep (
        .opa       (a_q),
        .opb       (b_q),
        .is_signed (op_q.is_signed),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_a     (neg_a),
        .neg_b     (neg_b)
    );

    mdu_mul_step #(.W(W)) u_mul (
        .work_in  (work_q),
        .mcand    (opnd_q),
        .work_out (mul_next)
    );

    mdu_div_step #(.W(W)) u_div (
        .work_in  (work_q),
        .dvsr     (opnd_q),
        .work_out (div_next)
    );

    assign step_next = op_q.is_div ? div_next : mul_next;

    mdu_finish #(.W(W)) u_fin (
        .work     (step_next),
        .is_div   (op_q.is_div),
        .neg_a    (neg_a_q),
        .neg_b    (neg_b_q),
        .div_zero (div_zero_q),
        .dividend (a_q),
        .res_hi   (fin_hi),
        .res_lo   (fin_lo)
    );

    // Sequencer: latch the command, set up the operands, step, then write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            a_q        <= '0;
            b_q        <= '0;
            opnd_q     <= '0;
            neg_a_q    <= 1'b0;
            neg_b_q    <= 1'b0;
            div_zero_q <= 1'b0;
            work_q     <= '0;
            step_q     <= '0;
            hi_q       <= '0;
            lo_q       <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && is_start) begin
                        op_q.is_div    <= cmd_func[1];
                        op_q.is_signed <= !cmd_func[0];
                        a_q            <= cmd_rs;
                        b_q            <= cmd_rt;
                        state_q        <= ST_SETUP;
                    end else if (accept && is_wr_hi) begin
                        hi_q <= cmd_rs;
                    end else if (accept && is_wr_lo) begin
                        lo_q <= cmd_rs;
                    end
                end
                ST_SETUP: begin
                    work_q     <= {{W{1'b0}}, (op_q.is_div ? mag_a : mag_b)};
                    opnd_q     <= op_q.is_div ? mag_b : mag_a;
                    neg_a_q    <= neg_a;
                    neg_b_q    <= neg_b;
                    div_zero_q <= (b_q == '0);
                    step_q     <= '0;
                    state_q    <= ST_ITER;
                end
                ST_ITER: begin
                    work_q <= step_next;
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        hi_q    <= fin_hi;
                        lo_q    <= fin_lo;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdu_checker.sv
// Protocol and timing properties of the multiply/divide unit, bound to the top.
// Assumes the busy window is one setup cycle plus W steps.
module mdu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [5:0]   cmd_func,
    input logic [W-1:0] cmd_rs,
    input logic         cmd_ready,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    localparam int BW = $clog2(W + 2) + 1;
    localparam logic [BW-1:0] BUSY_LEN = BW'(W + 1);

    logic [BW-1:0] busy_cnt;

    // Count the consecutive cycles in which busy is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_func[5:2] == 4'b0110) |=> busy); // R6
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == BUSY_LEN)); // R6
    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q))); // R6
    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_valid); // R7
    AST_WR_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_func == 6'h11) |=>
            (hi_q == $past(cmd_rs) && $stable(lo_q) && !busy)); // R8
    AST_WR_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_func == 6'h13) |=>
            (lo_q == $past(cmd_rs) && $stable(hi_q) && !busy)); // R8
endmodule

bind muldiv_unit mdu_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_func  (cmd_func),
    .cmd_rs    (cmd_rs),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_func = 6'h0;
    logic [31:0] cmd_rs = '0;
    logic [31:0] cmd_rt = '0;
    logic        cmd_ready, busy, rd_valid;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    muldiv_unit #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_rs(cmd_rs), .cmd_rt(cmd_rt), .cmd_ready(cmd_ready), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {HI, LO} from the requirements (R2..R5).
    function automatic logic [63:0] model(logic [5:0] f, logic [31:0] a, logic [31:0] b);
        longint x, y, q, r;
        logic [63:0] res;
        res = '0;
        if (f == 6'h18) begin
            x = longint'($signed(a));
            y = longint'($signed(b));
            res = 64'(x * y);
        end else if (f == 6'h19) begin
            res = {32'h0, a} * {32'h0, b};
        end else if (b == 32'h0) begin
            res = {a, 32'hffff_ffff};
        end else if (f == 6'h1a) begin
            x = longint'($signed(a));
            y = longint'($signed(b));
            q = x / y;
            r = x % y;
            res = {r[31:0], q[31:0]};
        end else begin
            res = {a % b, a / b};
        end
        return res;
    endfunction

    // Present a command at the falling edge until it is accepted.
    task automatic issue(logic [5:0] f, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_rs = a; cmd_rt = b;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic rd(logic [5:0] f, output logic [31:0] v, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f;
        #1;
        check(req, {63'h0, rd_valid}, 64'h1);
        v = rd_data;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    // Run one operation, check its busy length (R6) and result.
    task automatic run_op(logic [5:0] f, logic [31:0] a, logic [31:0] b, string req);
        int n;
        logic [31:0] h, l;
        issue(f, a, b);
        n = 0;
        @(negedge clk);
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R6 busy length", 64'(n), 64'd33);
        rd(6'h10, h, "R9 read HI valid");
        rd(6'h12, l, "R9 read LO valid");
        check(req, {h, l}, model(f, a, b));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] h, l, v;
        logic [31:0] r_a, r_b;
        logic [5:0]  r_f;
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state
        @(negedge clk);
        check("R11 busy after reset", {63'h0, busy}, 64'h0);
        rd(6'h10, h, "R11 read");
        rd(6'h12, l, "R11 read");
        check("R11 HI/LO after reset", {h, l}, 64'h0);

        // R8: writes change one register, visible next cycle
        issue(6'h11, 32'hdead_beef, 32'h0);
        check("R8 busy stays low", {63'h0, busy}, 64'h0);
        rd(6'h10, h, "R8 read");
        rd(6'h12, l, "R8 read");
        check("R8 write HI", {h, l}, {32'hdead_beef, 32'h0});
        issue(6'h13, 32'h1234_5678, 32'h0);
        rd(6'h10, h, "R8 read");
        rd(6'h12, l, "R8 read");
        check("R8 write LO", {h, l}, {32'hdead_beef, 32'h1234_5678});

        // R9: read is non-destructive
        rd(6'h10, h, "R9 read");
        check("R9 HI unchanged by reads", {32'h0, h}, {32'h0, 32'hdead_beef});

        // R10: unlisted codes have no effect
        issue(6'h14, 32'h1111_1111, 32'h2222_2222);
        check("R10 busy after unlisted code", {63'h0, busy}, 64'h0);
        issue(6'h00, 32'h3333_3333, 32'h4444_4444);
        issue(6'h1c, 32'h5555_5555, 32'h6666_6666);
        check("R10 busy after unlisted code", {63'h0, busy}, 64'h0);
        rd(6'h10, h, "R10 read");
        rd(6'h12, l, "R10 read");
        check("R10 HI/LO unchanged", {h, l}, {32'hdead_beef, 32'h1234_5678});

        // R1/R2: multiply corners
        run_op(6'h18, 32'hffff_ffff, 32'hffff_ffff, "R2 signed -1*-1");
        run_op(6'h19, 32'hffff_ffff, 32'hffff_ffff, "R2 unsigned max*max");
        run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R2 signed min*min");
        run_op(6'h18, 32'h0000_0007, 32'hffff_fffd, "R2 signed 7*-3");
        run_op(6'h19, 32'h0001_0000, 32'h0001_0000, "R1 unsigned code");
        // R3/R4: divide corners
        run_op(6'h1b, 32'd100, 32'd7, "R3 unsigned 100/7");
        run_op(6'h1b, 32'hffff_ffff, 32'd1, "R3 unsigned max/1");
        run_op(6'h1a, 32'hffff_fff9, 32'd2, "R4 signed -7/2");
        run_op(6'h1a, 32'd7, 32'hffff_fffe, "R4 signed 7/-2");
        run_op(6'h1a, 32'hffff_fff9, 32'hffff_fffe, "R4 signed -7/-2");
        run_op(6'h1a, 32'h8000_0000, 32'hffff_ffff, "R4 signed min/-1");
        check("R4 min/-1 value", model(6'h1a, 32'h8000_0000, 32'hffff_ffff),
              {32'h0, 32'h8000_0000});
        // R5: divide by zero
        run_op(6'h1a, 32'hffff_fffb, 32'h0, "R5 signed -5/0");
        run_op(6'h1b, 32'd123, 32'h0, "R5 unsigned 123/0");
        run_op(6'h1a, 32'h0, 32'h0, "R5 0/0");

        // R7: read held off during an operation
        issue(6'h19, 32'd9, 32'd11);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = 6'h10;
        #1;
        n = 0;
        while (!cmd_ready && n < 100) begin
            if (rd_valid) check("R7 rd_valid while stalled", 64'h1, 64'h0);
            n++;
            @(negedge clk); #1;
        end
        check("R7 read stall length", 64'(n), 64'd33);
        check("R7 stalled read data", {63'h0, rd_valid, rd_data}, {31'h0, 1'b1, 32'h0});
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        rd(6'h12, l, "R7 read");
        check("R7 LO after stall", {32'h0, l}, 64'd99);

        // R7: a write presented during busy never takes effect
        issue(6'h1b, 32'd50, 32'd8);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = 6'h11; cmd_rs = 32'hbad0_bad0;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        rd(6'h10, h, "R7 read");
        rd(6'h12, l, "R7 read");
        check("R7 write during busy ignored", {h, l}, {32'd2, 32'd6});

        // Random mix of all four operations
        for (int i = 0; i < 60; i++) begin
            r_f = 6'h18 + 6'($urandom_range(0, 3));
            r_a = $urandom();
            r_b = $urandom();
            case ($urandom_range(0, 7))
                0: r_b = 32'h0;
                1: r_a = 32'h8000_0000;
                2: r_b = 32'($urandom_range(1, 15));
                default: ;
            endcase
            run_op(r_f, r_a, r_b, "R2 R3 R4 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule